// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Sequencer

This block runs the refill of one cache line after a miss, when the memory bus is narrower than the line. It takes a miss address, asks memory for the bus beat that holds the missed word first, and expects the remaining beats of the line in wrapped order. With the default settings a beat is 8 bytes, a line is 32 bytes and a processor word is 4 bytes. The beat order is critical beat, then +1, +2 and +3, each taken modulo the beat count. For a miss at byte 0x95 the bus delivers 0x90, 0x98, 0x80 and then 0x88.

When the critical beat arrives, the missed word goes to the processor in the same cycle together with a restart strobe. The processor can then resume while the other beats are still being written. Every beat is written to the data array at the slot given by its own address, not by the order in which it arrived. The last beat carries a line-complete strobe, which the tag logic uses to mark the line valid.

While the fill runs, a probe port reports whether a later processor access to the same line must stall. It must stall when its beat has not yet been written. Only one fill is in flight at a time.

Top module: `cwf_line_fill`

## Requirements
- R1: `fill_busy` is 0 after reset. It rises in the cycle after a miss is accepted and falls in the cycle after the fourth beat is written.
- R2: `mem_req_valid` is a single-cycle pulse in the first busy cycle. `mem_req_addr` equals the miss address with its three low bits cleared.
- R3: The k-th accepted beat (k = 0..3) is written with `arr_we` in the cycle it arrives. It goes to slot `arr_beat` = (miss_addr[4:3] + k) mod 4 of line `arr_line` = miss_addr[31:5], with `arr_wdata` equal to the beat data.
- R4: `cpu_restart` is 1 only in the cycle the first beat of a fill arrives. `cpu_word` then carries bits 31:0 of that beat when miss_addr[2] is 0, and bits 63:32 when it is 1.
- R5: `arr_line_done` is 1 only with the fourth beat write of a fill.
- R6: `probe_stall` is 1 only while busy, for a valid probe that hits the line being filled and whose beat (probe_addr[4:3]) was not written in an earlier cycle. A probe of any other line never stalls.
- R7: A beat presented while idle, or in the request cycle, writes nothing and raises no restart.
- R8: A miss presented while busy is ignored. No second request pulse appears, and the line being filled does not change.
- R9: After reset `mem_req_valid`, `arr_we`, `cpu_restart` and `arr_line_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missed word |
| fill_busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 32 | Address of the critical beat |
| mem_beat_valid | input | 1 | Returned beat present |
| mem_beat_data | input | 64 | Returned beat data |
| cpu_restart | output | 1 | Missed word delivered, processor may resume |
| cpu_word | output | 32 | Missed word |
| arr_we | output | 1 | Data array write enable |
| arr_line | output | 27 | Line address of the write |
| arr_beat | output | 2 | Beat slot within the line |
| arr_wdata | output | 64 | Write data |
| arr_line_done | output | 1 | Final beat written, line may be marked valid |
| probe_valid | input | 1 | Processor access to check |
| probe_addr | input | 32 | Address of that access |
| probe_stall | output | 1 | Access must wait for its beat |

## Verification
A wrong beat counter or wrong critical index shows up at once on `arr_beat` during the write of the affected beat, and the bench checks it against the address arithmetic on every beat. A corrupted arrived mask first appears on `probe_stall`. Probes of all four slots are made in every gap between beats, so such an error is caught within one beat. An error in the busy or state logic appears as a missing or extra request pulse, a write taken while idle, or `fill_busy` still high one cycle after the fourth beat.

// File: rtl/cwf_pkg.sv
// Shared types for the critical-word-first refill sequencer.
package cwf_pkg;
    // Fill controller phases: waiting, request cycle, collecting beats.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } fill_st_t;
endpackage

// File: rtl/cwf_beat_seq.sv
// Beat sequencer: holds the critical beat index, counts accepted beats and
// yields the wrapped slot of the current beat plus a mask of written slots.
// Assumes BEATS is a power of two, so the slot wraps by plain truncation.
module cwf_beat_seq #(
    parameter int BEATS = 4,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             beat_acc,
    output logic [IDX_W-1:0] cur_idx,
    output logic             first,
    output logic             last,
    output logic [BEATS-1:0] arrived
);
    logic [IDX_W-1:0] crit_q;
    logic [IDX_W-1:0] cnt_q;

    // Current slot: critical slot plus beats already taken, wrapping.
    assign cur_idx = crit_q + cnt_q;
    assign first   = (cnt_q == '0);
    assign last    = (cnt_q == IDX_W'(BEATS - 1));

    // Latch the critical slot and clear the count when a fill starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            crit_q <= start_idx;
            cnt_q  <= '0;
        end else if (beat_acc) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Record each written slot; clear the mask at fill start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arrived <= '0;
        end else if (start) begin
            arrived <= '0;
        end else if (beat_acc) begin
            arrived[cur_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/cwf_word_pick.sv
// Word selector: picks one processor word out of a bus beat.
// Assumes the beat holds at least two words; word 0 is the low bits.
module cwf_word_pick #(
    parameter int BEAT_W = 64,
    parameter int WORD_W = 32,
    localparam int WPB   = BEAT_W / WORD_W,
    localparam int SEL_W = (WPB > 1) ? $clog2(WPB) : 1
) (
    input  logic [BEAT_W-1:0] beat,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] words [WPB];

    // Slice the beat into its words.
    for (genvar i = 0; i < WPB; i++) begin : g_slice
        assign words[i] = beat[i*WORD_W +: WORD_W];
    end

    // Select the requested word.
    assign word = words[sel];
endmodule

// File: rtl/cwf_probe.sv
// Probe comparator: a processor access stalls when it targets the line being
// filled and its beat slot has not been written yet.
module cwf_probe #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int BYTE_W = 3,
    parameter int BEATS  = 4,
    localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              busy,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [BEATS-1:0]  arrived,
    output logic              stall
);
    logic [LINE_W-1:0] p_line;
    logic [IDX_W-1:0]  p_idx;
    logic              same_line;

    assign p_line    = probe_addr[ADDR_W-1:OFF_W];
    assign p_idx     = probe_addr[BYTE_W +: IDX_W];
    assign same_line = (p_line == fill_line);

    // Stall only for a live fill of the same line with the slot still empty.
    always_comb begin
        stall = probe_valid && busy && same_line && !arrived[p_idx];
    end
endmodule

// File: rtl/cwf_line_fill.sv
// Critical-word-first line refill sequencer (top).
// Accepts one miss at a time, requests the beat holding the missed word,
// forwards that word to the processor as soon as its beat returns, and
// writes every beat into the data array at its own slot. Assumes memory
// returns the beats of a line in wrapped order starting at the request.
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    localparam int BEATS    = LINE_BYTES / BEAT_BYTES,
    localparam int IDX_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int BYTE_W   = $clog2(BEAT_BYTES),
    localparam int OFF_W    = $clog2(LINE_BYTES),
    localparam int LINE_W   = ADDR_W - OFF_W,
    localparam int BEAT_W   = 8 * BEAT_BYTES,
    localparam int WORD_W   = 8 * WORD_BYTES,
    localparam int WPB      = BEAT_BYTES / WORD_BYTES,
    localparam int SEL_W    = (WPB > 1) ? $clog2(WPB) : 1,
    localparam int WORD_LSB = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_beat_valid,
    input  logic [BEAT_W-1:0] mem_beat_data,
    output logic              cpu_restart,
    output logic [WORD_W-1:0] cpu_word,
    output logic              arr_we,
    output logic [LINE_W-1:0] arr_line,
    output logic [IDX_W-1:0]  arr_beat,
    output logic [BEAT_W-1:0] arr_wdata,
    output logic              arr_line_done,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_stall
);
    fill_st_t          st_q, st_d;
    logic [LINE_W-1:0] line_q;
    logic [SEL_W-1:0]  wsel_q;
    logic              accept;
    logic              beat_acc;
    logic [IDX_W-1:0]  cur_idx;
    logic              first_beat;
    logic              last_beat;
    logic [BEATS-1:0]  arrived;
    logic [WORD_W-1:0] picked;

    assign accept   = (st_q == ST_IDLE) && miss_valid;
    assign beat_acc = (st_q == ST_FILL) && mem_beat_valid;

    // Next-state logic for the fill controller.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (accept) st_d = ST_REQ;
            ST_REQ:  st_d = ST_FILL;
            ST_FILL: if (beat_acc && last_beat) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture line address and word select of an accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            wsel_q <= '0;
        end else if (accept) begin
            line_q <= miss_addr[ADDR_W-1:OFF_W];
            wsel_q <= miss_addr[WORD_LSB +: SEL_W];
        end
    end

    cwf_beat_seq #(
        .BEATS(BEATS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_idx(miss_addr[BYTE_W +: IDX_W]),
        .beat_acc (beat_acc),
        .cur_idx  (cur_idx),
        .first    (first_beat),
        .last     (last_beat),
        .arrived  (arrived)
    );

    cwf_word_pick #(
        .BEAT_W(BEAT_W),
        .WORD_W(WORD_W)
    ) u_pick (
        .beat(mem_beat_data),
        .sel (wsel_q),
        .word(picked)
    );

    cwf_probe #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .BYTE_W(BYTE_W),
        .BEATS (BEATS)
    ) u_probe (
        .probe_valid(probe_valid),
        .probe_addr (probe_addr),
        .busy       (fill_busy),
        .fill_line  (line_q),
        .arrived    (arrived),
        .stall      (probe_stall)
    );

    // Request and busy outputs come straight from the registered state.
    assign fill_busy     = (st_q != ST_IDLE);
    assign mem_req_valid = (st_q == ST_REQ);
    assign mem_req_addr  = {line_q, cur_idx, {BYTE_W{1'b0}}};

    // Data array write port: each beat lands in its own slot.
    assign arr_we        = beat_acc;
    assign arr_line      = line_q;
    assign arr_beat      = cur_idx;
    assign arr_wdata     = mem_beat_data;
    assign arr_line_done = beat_acc && last_beat;

    // Early restart: forward the missed word with the critical beat.
    assign cpu_restart   = beat_acc && first_beat;
    assign cpu_word      = cpu_restart ? picked : '0;
endmodule

// File: rtl/cwf_fill_checker.sv
// Protocol checker for the refill sequencer, bound to the top module.
// Tracks writes per fill with its own counter.
module cwf_fill_checker #(
    parameter int BEATS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic fill_busy,
    input logic mem_req_valid,
    input logic cpu_restart,
    input logic arr_we,
    input logic arr_line_done,
    input logic probe_stall
);
    logic [7:0] wr_cnt;

    // Count writes in the current fill; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !fill_busy) wr_cnt <= '0;
        else if (arr_we)          wr_cnt <= wr_cnt + 1'b1;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R2
    AST_REQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $rose(fill_busy)); // R2
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        arr_line_done |=> !fill_busy); // R1
    AST_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (fill_busy && !mem_req_valid)); // R7
    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart |-> (arr_we && wr_cnt == 8'd0)); // R4
    AST_DONE_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        arr_line_done |-> (arr_we && wr_cnt == 8'(BEATS - 1))); // R5
    AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_busy |-> !probe_stall); // R6
endmodule

bind cwf_line_fill cwf_fill_checker #(
    .BEATS(BEATS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_busy    (fill_busy),
    .mem_req_valid(mem_req_valid),
    .cpu_restart  (cpu_restart),
    .arr_we       (arr_we),
    .arr_line_done(arr_line_done),
    .probe_stall  (probe_stall)
);

// File: tb/cwf_line_fill_bench.sv
// Sweep bench: every word offset of several lines, variable beat gaps,
// probes of all slots between beats, stray beats and misses while busy.
module cwf_line_fill_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        fill_busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_beat_valid = 1'b0;
    logic [63:0] mem_beat_data = '0;
    logic        cpu_restart;
    logic [31:0] cpu_word;
    logic        arr_we;
    logic [26:0] arr_line;
    logic [1:0]  arr_beat;
    logic [63:0] arr_wdata;
    logic        arr_line_done;
    logic        probe_valid = 1'b0;
    logic [31:0] probe_addr = '0;
    logic        probe_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cwf_line_fill u_cwf_line_fill (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_busy(fill_busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
        .cpu_restart(cpu_restart), .cpu_word(cpu_word),
        .arr_we(arr_we), .arr_line(arr_line), .arr_beat(arr_beat),
        .arr_wdata(arr_wdata), .arr_line_done(arr_line_done),
        .probe_valid(probe_valid), .probe_addr(probe_addr),
        .probe_stall(probe_stall)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_of(input logic [31:0] baddr);
        return {baddr ^ 32'hF00D_0000, baddr * 32'd3 + 32'd1};
    endfunction

    task automatic run_fill(input logic [31:0] a, input int gap);
        logic [3:0]  got;
        logic [1:0]  crit;
        logic [31:0] lbase;
        crit  = a[4:3];
        lbase = {a[31:5], 5'd0};
        got   = '0;
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a;
        #1 chk("R1 idle before accept", 64'(fill_busy), 64'd0);
        @(negedge clk);
        miss_valid = 1'b0;
        mem_beat_valid = 1'b1; mem_beat_data = 64'hDEAD_BEEF_0BAD_F00D;
        #1;
        chk("R1 busy after accept", 64'(fill_busy), 64'd1);
        chk("R2 request pulse", 64'(mem_req_valid), 64'd1);
        chk("R2 request addr", 64'(mem_req_addr), 64'(a & ~32'd7));
        chk("R7 no write in request cycle", 64'(arr_we), 64'd0);
        chk("R7 no restart in request cycle", 64'(cpu_restart), 64'd0);
        for (int k = 0; k < 4; k++) begin
            logic [1:0]  slot;
            logic [31:0] baddr;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                mem_beat_valid = 1'b0;
                miss_valid = 1'b1; miss_addr = a ^ 32'h0001_0040;
                probe_valid = 1'b1;
                #1;
                chk("R8 no request while busy", 64'(mem_req_valid), 64'd0);
                chk("R1 busy during fill", 64'(fill_busy), 64'd1);
                for (int j = 0; j < 4; j++) begin
                    probe_addr = lbase + 32'(j * 8) + 32'd4;
                    #1 chk("R6 probe same line", 64'(probe_stall), 64'(!got[j]));
                end
                probe_addr = lbase + 32'h40;
                #1 chk("R6 probe other line", 64'(probe_stall), 64'd0);
            end
            @(negedge clk);
            miss_valid = 1'b0; probe_valid = 1'b0;
            slot  = crit + 2'(k);
            baddr = lbase + 32'(slot) * 32'd8;
            mem_beat_valid = 1'b1; mem_beat_data = beat_of(baddr);
            #1;
            chk("R3 write enable", 64'(arr_we), 64'd1);
            chk("R3 write slot", 64'(arr_beat), 64'(slot));
            chk("R3 write line / R8 line kept", 64'(arr_line), 64'(a[31:5]));
            chk("R3 write data", arr_wdata, beat_of(baddr));
            chk("R4 restart strobe", 64'(cpu_restart), 64'(k == 0));
            if (k == 0)
                chk("R4 critical word", 64'(cpu_word),
                    a[2] ? 64'(beat_of(baddr) >> 32) : 64'(beat_of(baddr) & 64'hFFFF_FFFF));
            chk("R5 line done", 64'(arr_line_done), 64'(k == 3));
            got[slot] = 1'b1;
        end
        @(negedge clk);
        mem_beat_valid = 1'b0;
        probe_valid = 1'b1; probe_addr = a;
        #1;
        chk("R1 busy falls after last beat", 64'(fill_busy), 64'd0);
        chk("R6 no stall after fill", 64'(probe_stall), 64'd0);
        probe_valid = 1'b0;
        mem_beat_valid = 1'b1;
        #1;
        chk("R7 stray beat while idle", 64'(arr_we), 64'd0);
        chk("R7 no restart while idle", 64'(cpu_restart), 64'd0);
        mem_beat_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] lines [3];
        lines[0] = 32'h0000_0080;
        lines[1] = 32'h1234_5660;
        lines[2] = 32'hFFFF_FFE0;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset busy", 64'(fill_busy), 64'd0);
        chk("R9 reset request", 64'(mem_req_valid), 64'd0);
        chk("R9 reset write", 64'(arr_we), 64'd0);
        chk("R9 reset restart", 64'(cpu_restart), 64'd0);
        chk("R9 reset done", 64'(arr_line_done), 64'd0);
        rst_n = 1'b1;
        for (int l = 0; l < 3; l++)
            for (int w = 0; w < 8; w++)
                run_fill(lines[l] + 32'(w * 4) + 32'(w % 4), 1 + ((l + w) % 3));
        run_fill(32'h0000_0095, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule